// File: doc/BRIEF.md
# Debug Halt and Resume Controller

This block holds the debug-mode state of a small core that runs in machine (M), supervisor (S) and user (U) privilege. Each cycle it receives an external halt request and decoded flags for the instruction at hand (breakpoint, debug-return, wait-for-interrupt), along with that instruction's PC and the current privilege. From these it settles on one outcome. It can enter debug mode, restart the debug ROM, resume from debug mode, raise a breakpoint trap, raise an illegal-instruction trap, put the core to sleep, or do nothing.

Any redirect appears combinationally in the same cycle as the triggering input. The redirect comes with its target and, when the privilege must change, the new privilege value. Mode, sleep state and the two debug registers (control/status and saved PC) update on the following clock edge. While in debug mode, the ROM code reads and writes the two registers through a simple select/write port.

Top module: `halt_ctrl`

## Requirements
- R1: After synchronous reset, `dbg_mode_o` and `sleep_o` are 0, no redirect is raised, the control/status register reads 0x0000_0003 and the saved PC reads 0.
- R2: A halt request outside debug mode redirects the same cycle to `ROM_BASE` and loads privilege M (3). From the next cycle `dbg_mode_o` is 1, the saved PC holds the `pc_i` of that cycle, control/status bits [8:6] hold 3 and bits [1:0] hold the privilege at entry (M=3, S=1, U=0).
- R3: A breakpoint outside debug mode, while the enable bit for the current privilege is set, enters debug mode like R2 but writes cause 1 into bits [8:6]. The enable bits are bit 15 for M, bit 13 for S and bit 12 for U.
- R4: A breakpoint outside debug mode whose enable bit is clear, or that occurs at the invalid privilege 2, pulses `brk_exc_o` and redirects to `TRAP_VEC`. Mode, control/status and saved PC are left unchanged.
- R5: A breakpoint inside debug mode redirects to `ROM_BASE` without a privilege load. The core stays in debug mode, and control/status and saved PC are unchanged.
- R6: A debug-return outside debug mode pulses `illegal_o`, redirects to `TRAP_VEC` and does not change the mode.
- R7: A debug-return inside debug mode redirects to the saved PC and loads the privilege from control/status bits [1:0], with the invalid value 2 loaded as M. Debug mode ends on the next cycle.
- R8: A wait-for-interrupt outside debug mode sets `sleep_o` from the next cycle. While the core sleeps, instruction flags are ignored. A halt request then clears `sleep_o` and enters debug mode.
- R9: A wait-for-interrupt inside debug mode is a no-op: no redirect, and `sleep_o` stays 0.
- R10: A halt request inside debug mode is ignored: no redirect, and both registers are unchanged.
- R11: When a halt request and an instruction flag arrive in the same cycle outside debug mode, the halt request wins (cause 3, no trap).
- R12: `csr_sel_i` = 0 selects control/status and 1 selects the saved PC, and `csr_rdata_o` returns the selected register combinationally. Writes take effect only in debug mode. In control/status only bits 15, 13, 12 and [1:0] are writable; the saved PC takes the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req_i | input | 1 | External halt request |
| ebrk_i | input | 1 | Current instruction is a breakpoint |
| dret_i | input | 1 | Current instruction is a debug-return |
| wfi_i | input | 1 | Current instruction is wait-for-interrupt |
| pc_i | input | XLEN | PC of the current instruction |
| priv_i | input | 2 | Current privilege (3 M, 1 S, 0 U) |
| csr_we_i | input | 1 | Debug register write strobe |
| csr_sel_i | input | 1 | 0 control/status, 1 saved PC |
| csr_wdata_i | input | XLEN | Debug register write data |
| csr_rdata_o | output | XLEN | Selected debug register |
| dbg_mode_o | output | 1 | Core is in debug mode |
| sleep_o | output | 1 | Core is stalled in wait-for-interrupt |
| redir_o | output | 1 | Redirect fetch this cycle |
| redir_pc_o | output | XLEN | Redirect target |
| priv_load_o | output | 1 | Load new privilege this cycle |
| priv_val_o | output | 2 | Privilege to load |
| brk_exc_o | output | 1 | Breakpoint trap raised |
| illegal_o | output | 1 | Illegal-instruction trap raised |

## Verification
The main decision is exercised with each flag alone, both inside and outside debug mode. This separates debug entry, ROM restart and resume from the two trap paths. Breakpoints are issued at U privilege with its enable bit set, and at M and at the invalid privilege 2 with the bits clear, so the per-privilege bit selection is distinguished from a blanket enable. Combined halt-plus-breakpoint stimulus shows the priority order. Flags issued while the core sleeps show that sleep masks instructions but not halts. Register reads after each event show whether cause, privilege and saved PC were written or left alone.

// File: rtl/halt_pkg.sv
`timescale 1ns/1ps
package halt_pkg;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_HALT,
        EV_BRK_ENTER,
        EV_BRK_TRAP,
        EV_ROM_AGAIN,
        EV_RESUME,
        EV_BAD_RESUME,
        EV_DOZE
    } dbg_event_e;

    typedef enum logic [1:0] {
        TGT_ROM,
        TGT_SAVED_PC,
        TGT_TRAP
    } tgt_kind_e;

    typedef struct packed {
        logic      valid;
        tgt_kind_e kind;
        logic      load_priv;
        logic      from_dcsr;
        logic      brk_trap;
        logic      bad_instr;
    } route_t;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [2:0] CAUSE_BRK  = 3'd1;
    localparam logic [2:0] CAUSE_HALT = 3'd3;

    localparam int PRV_LSB   = 0;
    localparam int CAUSE_LSB = 6;
    localparam int EN_U_BIT  = 12;
    localparam int EN_S_BIT  = 13;
    localparam int EN_M_BIT  = 15;

    localparam logic [31:0] DCSR_RESET = 32'h0000_0003;
    localparam logic [31:0] DCSR_WMASK =
        (32'd1 << EN_M_BIT) | (32'd1 << EN_S_BIT) | (32'd1 << EN_U_BIT) | 32'h3;

    function automatic logic brk_enabled(input logic [31:0] ctl, input logic [1:0] prv);
        case (prv)
            PRIV_M:  return ctl[EN_M_BIT];
            PRIV_S:  return ctl[EN_S_BIT];
            PRIV_U:  return ctl[EN_U_BIT];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] resume_priv(input logic [1:0] prv);
        return (prv == 2'd2) ? PRIV_M : prv;
    endfunction

endpackage

// File: rtl/halt_decide.sv
`timescale 1ns/1ps
module halt_decide
    import halt_pkg::*;
(
    input  logic        in_dbg,
    input  logic        asleep,
    input  logic        halt_req,
    input  logic        ebrk,
    input  logic        dret,
    input  logic        wfi,
    input  logic [1:0]  priv,
    input  logic [31:0] ctl,
    output dbg_event_e  ev
);

    always_comb begin
        ev = EV_NONE;
        if (!in_dbg) begin
            if (halt_req)
                ev = EV_HALT;
            else if (asleep)
                ev = EV_NONE;
            else if (ebrk)
                ev = brk_enabled(ctl, priv) ? EV_BRK_ENTER : EV_BRK_TRAP;
            else if (dret)
                ev = EV_BAD_RESUME;
            else if (wfi)
                ev = EV_DOZE;
        end else begin
            if (ebrk)
                ev = EV_ROM_AGAIN;
            else if (dret)
                ev = EV_RESUME;
        end
    end

endmodule

// File: rtl/halt_regs.sv
`timescale 1ns/1ps
module halt_regs
    import halt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  dbg_event_e      ev,
    input  logic [XLEN-1:0] pc,
    input  logic [1:0]      priv,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [XLEN-1:0] wr_data,
    output logic            in_dbg,
    output logic            asleep,
    output logic [31:0]     ctl,
    output logic [XLEN-1:0] saved_pc
);

    logic            enter;
    logic [2:0]      cause;
    logic [31:0]     ctl_n;
    logic [XLEN-1:0] spc_n;
    logic [31:0]     wr_ctl;

    assign enter  = (ev == EV_HALT) || (ev == EV_BRK_ENTER);
    assign cause  = (ev == EV_HALT) ? CAUSE_HALT : CAUSE_BRK;
    assign wr_ctl = wr_data[31:0];

    always_comb begin
        ctl_n = ctl;
        spc_n = saved_pc;
        if (enter) begin
            ctl_n[CAUSE_LSB +: 3] = cause;
            ctl_n[PRV_LSB +: 2]   = priv;
            spc_n                 = pc;
        end else if (in_dbg && wr_en) begin
            if (wr_sel)
                spc_n = wr_data;
            else
                ctl_n = (ctl & ~DCSR_WMASK) | (wr_ctl & DCSR_WMASK);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_dbg   <= 1'b0;
            asleep   <= 1'b0;
            ctl      <= DCSR_RESET;
            saved_pc <= '0;
        end else begin
            ctl      <= ctl_n;
            saved_pc <= spc_n;
            if (enter)
                in_dbg <= 1'b1;
            else if (ev == EV_RESUME)
                in_dbg <= 1'b0;
            if (ev == EV_HALT)
                asleep <= 1'b0;
            else if (ev == EV_DOZE)
                asleep <= 1'b1;
        end
    end

endmodule

// File: rtl/halt_target.sv
`timescale 1ns/1ps
module halt_target
    import halt_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] ROM_BASE = 'h800,
    parameter logic [XLEN-1:0] TRAP_VEC = 'h40
) (
    input  dbg_event_e      ev,
    input  logic [XLEN-1:0] saved_pc,
    input  logic [1:0]      saved_prv,
    output logic            redir,
    output logic [XLEN-1:0] redir_pc,
    output logic            priv_load,
    output logic [1:0]      priv_val,
    output logic            brk_trap,
    output logic            bad_instr
);

    route_t rt;

    always_comb begin
        rt = '{valid: 1'b0, kind: TGT_ROM, load_priv: 1'b0, from_dcsr: 1'b0,
               brk_trap: 1'b0, bad_instr: 1'b0};
        case (ev)
            EV_HALT, EV_BRK_ENTER: begin
                rt.valid     = 1'b1;
                rt.load_priv = 1'b1;
            end
            EV_ROM_AGAIN: rt.valid = 1'b1;
            EV_RESUME: begin
                rt.valid     = 1'b1;
                rt.kind      = TGT_SAVED_PC;
                rt.load_priv = 1'b1;
                rt.from_dcsr = 1'b1;
            end
            EV_BRK_TRAP: begin
                rt.valid    = 1'b1;
                rt.kind     = TGT_TRAP;
                rt.brk_trap = 1'b1;
            end
            EV_BAD_RESUME: begin
                rt.valid     = 1'b1;
                rt.kind      = TGT_TRAP;
                rt.bad_instr = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        case (rt.kind)
            TGT_SAVED_PC: redir_pc = saved_pc;
            TGT_TRAP:     redir_pc = TRAP_VEC;
            default:      redir_pc = ROM_BASE;
        endcase
    end

    assign redir     = rt.valid;
    assign priv_load = rt.load_priv;
    assign priv_val  = rt.from_dcsr ? resume_priv(saved_prv) : PRIV_M;
    assign brk_trap  = rt.brk_trap;
    assign bad_instr = rt.bad_instr;

endmodule

// File: rtl/halt_ctrl.sv
`timescale 1ns/1ps
module halt_ctrl
    import halt_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] ROM_BASE = 'h800,
    parameter logic [XLEN-1:0] TRAP_VEC = 'h40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            halt_req_i,
    input  logic            ebrk_i,
    input  logic            dret_i,
    input  logic            wfi_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [1:0]      priv_i,
    input  logic            csr_we_i,
    input  logic            csr_sel_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    output logic [XLEN-1:0] csr_rdata_o,
    output logic            dbg_mode_o,
    output logic            sleep_o,
    output logic            redir_o,
    output logic [XLEN-1:0] redir_pc_o,
    output logic            priv_load_o,
    output logic [1:0]      priv_val_o,
    output logic            brk_exc_o,
    output logic            illegal_o
);

    dbg_event_e      ev;
    logic            in_dbg;
    logic            asleep;
    logic [31:0]     dcsr_w;
    logic [XLEN-1:0] dpc_w;

    halt_decide u_decide (
        .in_dbg   (in_dbg),
        .asleep   (asleep),
        .halt_req (halt_req_i),
        .ebrk     (ebrk_i),
        .dret     (dret_i),
        .wfi      (wfi_i),
        .priv     (priv_i),
        .ctl      (dcsr_w),
        .ev       (ev)
    );

    halt_regs #(.XLEN(XLEN)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .pc       (pc_i),
        .priv     (priv_i),
        .wr_en    (csr_we_i),
        .wr_sel   (csr_sel_i),
        .wr_data  (csr_wdata_i),
        .in_dbg   (in_dbg),
        .asleep   (asleep),
        .ctl      (dcsr_w),
        .saved_pc (dpc_w)
    );

    halt_target #(.XLEN(XLEN), .ROM_BASE(ROM_BASE), .TRAP_VEC(TRAP_VEC)) u_target (
        .ev        (ev),
        .saved_pc  (dpc_w),
        .saved_prv (dcsr_w[PRV_LSB +: 2]),
        .redir     (redir_o),
        .redir_pc  (redir_pc_o),
        .priv_load (priv_load_o),
        .priv_val  (priv_val_o),
        .brk_trap  (brk_exc_o),
        .bad_instr (illegal_o)
    );

    assign csr_rdata_o = csr_sel_i ? dpc_w : XLEN'(dcsr_w);
    assign dbg_mode_o  = in_dbg;
    assign sleep_o     = asleep;

endmodule

// File: rtl/halt_ctrl_chk.sv
`timescale 1ns/1ps
module halt_ctrl_chk #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] ROM_BASE = 'h800,
    parameter logic [XLEN-1:0] TRAP_VEC = 'h40
) (
    input logic            clk,
    input logic            rst,
    input logic            halt_req_i,
    input logic            ebrk_i,
    input logic            dret_i,
    input logic            wfi_i,
    input logic [XLEN-1:0] pc_i,
    input logic            csr_we_i,
    input logic            dbg_mode_o,
    input logic            sleep_o,
    input logic            redir_o,
    input logic [XLEN-1:0] redir_pc_o,
    input logic            priv_load_o,
    input logic [1:0]      priv_val_o,
    input logic            brk_exc_o,
    input logic            illegal_o,
    input logic [31:0]     dcsr_q,
    input logic [XLEN-1:0] dpc_q
);

    // R2
    halt_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (!dbg_mode_o && halt_req_i) |-> (redir_o && redir_pc_o == ROM_BASE
                                         && priv_load_o && priv_val_o == 2'd3));

    // R2
    halt_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!dbg_mode_o && halt_req_i) |=> (dbg_mode_o && dcsr_q[8:6] == 3'd3
                                         && dpc_q == $past(pc_i)));

    // R5
    rom_again_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode_o && ebrk_i && !csr_we_i) |=> (dbg_mode_o && $stable(dcsr_q) && $stable(dpc_q)));

    // R10
    halt_in_dbg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode_o && halt_req_i && !ebrk_i && !dret_i) |-> !redir_o);

    // R6
    dret_outside_chk: assert property (@(posedge clk) disable iff (rst)
        (!dbg_mode_o && !sleep_o && !halt_req_i && !ebrk_i && dret_i)
            |-> (illegal_o && redir_pc_o == TRAP_VEC));

    // R9
    wfi_in_dbg_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode_o && wfi_i) |=> !sleep_o);

    // R4
    trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({brk_exc_o, illegal_o}) && ((brk_exc_o || illegal_o) -> (redir_o && !priv_load_o)));

endmodule

bind halt_ctrl halt_ctrl_chk #(.XLEN(XLEN), .ROM_BASE(ROM_BASE), .TRAP_VEC(TRAP_VEC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .halt_req_i  (halt_req_i),
    .ebrk_i      (ebrk_i),
    .dret_i      (dret_i),
    .wfi_i       (wfi_i),
    .pc_i        (pc_i),
    .csr_we_i    (csr_we_i),
    .dbg_mode_o  (dbg_mode_o),
    .sleep_o     (sleep_o),
    .redir_o     (redir_o),
    .redir_pc_o  (redir_pc_o),
    .priv_load_o (priv_load_o),
    .priv_val_o  (priv_val_o),
    .brk_exc_o   (brk_exc_o),
    .illegal_o   (illegal_o),
    .dcsr_q      (dcsr_w),
    .dpc_q       (dpc_w)
);

// File: tb/sim_halt_ctrl.sv
`timescale 1ns/1ps
module sim_halt_ctrl;
    localparam int          XLEN = 32;
    localparam logic [31:0] ROM  = 32'h800;
    localparam logic [31:0] TRAP = 32'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt_req_i = 0, ebrk_i = 0, dret_i = 0, wfi_i = 0;
    logic [31:0] pc_i = 0;
    logic [1:0]  priv_i = 2'd3;
    logic        csr_we_i = 0, csr_sel_i = 0;
    logic [31:0] csr_wdata_i = 0;
    logic [31:0] csr_rdata_o, redir_pc_o;
    logic        dbg_mode_o, sleep_o, redir_o, priv_load_o, brk_exc_o, illegal_o;
    logic [1:0]  priv_val_o;

    always #2 clk = ~clk;

    halt_ctrl #(.XLEN(XLEN), .ROM_BASE(ROM), .TRAP_VEC(TRAP)) u0 (
        .clk(clk), .rst(rst), .halt_req_i(halt_req_i), .ebrk_i(ebrk_i), .dret_i(dret_i),
        .wfi_i(wfi_i), .pc_i(pc_i), .priv_i(priv_i), .csr_we_i(csr_we_i),
        .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
        .dbg_mode_o(dbg_mode_o), .sleep_o(sleep_o), .redir_o(redir_o),
        .redir_pc_o(redir_pc_o), .priv_load_o(priv_load_o), .priv_val_o(priv_val_o),
        .brk_exc_o(brk_exc_o), .illegal_o(illegal_o)
    );

    int checks = 0;
    int errors = 0;
    logic        c_redir, c_load, c_brk, c_ill;
    logic [31:0] c_pc;
    logic [1:0]  c_val;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic h, input logic e, input logic d, input logic w,
                         input logic [31:0] pc, input logic [1:0] prv);
        @(negedge clk);
        halt_req_i = h; ebrk_i = e; dret_i = d; wfi_i = w; pc_i = pc; priv_i = prv;
        #1;
        c_redir = redir_o; c_pc = redir_pc_o; c_load = priv_load_o;
        c_val = priv_val_o; c_brk = brk_exc_o; c_ill = illegal_o;
        @(negedge clk);
        halt_req_i = 0; ebrk_i = 0; dret_i = 0; wfi_i = 0;
        #0.5;
    endtask

    task automatic csr_wr(input logic sel, input logic [31:0] data);
        @(negedge clk);
        csr_we_i = 1; csr_sel_i = sel; csr_wdata_i = data;
        @(negedge clk);
        csr_we_i = 0;
        #0.5;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        csr_sel_i = sel;
        #0.1;
        v = csr_rdata_o;
    endtask

    task automatic expect_regs(input string req, input logic [31:0] dcsr_e, input logic [31:0] dpc_e);
        logic [31:0] v;
        rd(1'b0, v); chk(req, "dcsr", v, dcsr_e);
        rd(1'b1, v); chk(req, "dpc", v, dpc_e);
    endtask

    task automatic t_reset;
        chk("R1", "dbg_mode", dbg_mode_o, 0);
        chk("R1", "sleep", sleep_o, 0);
        chk("R1", "redir", redir_o, 0);
        expect_regs("R1", 32'h3, 32'h0);
    endtask

    task automatic t_halt_entry;
        issue(1, 0, 0, 0, 32'h100, 2'd1);
        chk("R2", "redir", c_redir, 1);
        chk("R2", "target", c_pc, ROM);
        chk("R2", "priv load", {c_load, c_val}, 3'b111);
        chk("R2", "dbg_mode", dbg_mode_o, 1);
        expect_regs("R2", 32'h0000_00C1, 32'h100);
    endtask

    task automatic t_halt_ignored;
        issue(1, 0, 0, 0, 32'h200, 2'd3);
        chk("R10", "redir", c_redir, 0);
        expect_regs("R10", 32'h0000_00C1, 32'h100);
    endtask

    task automatic t_csr_debug;
        csr_wr(1'b0, 32'hFFFF_FFFF);
        csr_wr(1'b1, 32'h300);
        expect_regs("R12", 32'h0000_B0C3, 32'h300);
    endtask

    task automatic t_rom_again;
        issue(0, 1, 0, 0, 32'h804, 2'd3);
        chk("R5", "redir", c_redir, 1);
        chk("R5", "target", c_pc, ROM);
        chk("R5", "no priv load", c_load, 0);
        chk("R5", "dbg_mode", dbg_mode_o, 1);
        expect_regs("R5", 32'h0000_B0C3, 32'h300);
    endtask

    task automatic t_wfi_dbg;
        issue(0, 0, 0, 1, 32'h808, 2'd3);
        chk("R9", "redir", c_redir, 0);
        chk("R9", "sleep", sleep_o, 0);
        chk("R9", "dbg_mode", dbg_mode_o, 1);
    endtask

    task automatic t_resume(input string req, input logic [31:0] tgt, input logic [1:0] pv);
        issue(0, 0, 1, 0, 32'h810, 2'd3);
        chk(req, "redir", c_redir, 1);
        chk(req, "target", c_pc, tgt);
        chk(req, "priv load", {c_load, c_val}, {1'b1, pv});
        chk(req, "dbg_mode", dbg_mode_o, 0);
    endtask

    task automatic t_brk_enter;
        issue(0, 1, 0, 0, 32'h400, 2'd0);
        chk("R3", "redir", c_redir, 1);
        chk("R3", "target", c_pc, ROM);
        chk("R3", "trap", c_brk, 0);
        chk("R3", "dbg_mode", dbg_mode_o, 1);
        expect_regs("R3", 32'h0000_B040, 32'h400);
    endtask

    task automatic t_brk_trap(input logic [1:0] prv);
        issue(0, 1, 0, 0, 32'h600, prv);
        chk("R4", "brk_exc", c_brk, 1);
        chk("R4", "target", c_pc, TRAP);
        chk("R4", "dbg_mode", dbg_mode_o, 0);
        expect_regs("R4", 32'h0000_00C2, 32'h480);
    endtask

    task automatic t_dret_illegal;
        issue(0, 0, 1, 0, 32'h610, 2'd3);
        chk("R6", "illegal", c_ill, 1);
        chk("R6", "target", c_pc, TRAP);
        chk("R6", "dbg_mode", dbg_mode_o, 0);
    endtask

    task automatic t_priority;
        issue(1, 1, 0, 0, 32'h500, 2'd3);
        chk("R11", "trap", c_brk, 0);
        chk("R11", "target", c_pc, ROM);
        expect_regs("R11", 32'h0000_00C3, 32'h500);
    endtask

    task automatic t_sleep;
        issue(0, 0, 0, 1, 32'h700, 2'd3);
        chk("R8", "redir on wfi", c_redir, 0);
        chk("R8", "sleep set", sleep_o, 1);
        issue(0, 1, 0, 0, 32'h700, 2'd3);
        chk("R8", "ebrk ignored", {c_redir, c_brk}, 0);
        issue(0, 0, 1, 0, 32'h700, 2'd3);
        chk("R8", "dret ignored", {c_redir, c_ill}, 0);
        chk("R8", "still asleep", sleep_o, 1);
        issue(1, 0, 0, 0, 32'h704, 2'd3);
        chk("R8", "wake redir", c_pc, ROM);
        chk("R8", "sleep cleared", sleep_o, 0);
        chk("R8", "dbg_mode", dbg_mode_o, 1);
        expect_regs("R8", 32'h0000_00C3, 32'h704);
    endtask

    bit done = 0;

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #0.5;
        t_reset();
        t_halt_entry();
        t_halt_ignored();
        t_csr_debug();
        t_rom_again();
        t_wfi_dbg();
        csr_wr(1'b0, 32'h0000_B000);
        t_resume("R7", 32'h300, 2'd0);
        t_brk_enter();
        t_resume("R7", 32'h400, 2'd0);
        issue(1, 0, 0, 0, 32'h480, 2'd0);
        csr_wr(1'b0, 32'h0000_0002);
        t_resume("R7", 32'h480, 2'd3);
        t_brk_trap(2'd3);
        t_brk_trap(2'd2);
        csr_wr(1'b0, 32'hFFFF_FFFF);
        expect_regs("R12", 32'h0000_00C2, 32'h480);
        t_dret_illegal();
        t_priority();
        t_resume("R7", 32'h500, 2'd3);
        t_sleep();
        t_resume("R7", 32'h704, 2'd3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule